// File: doc/BRIEF.md
# Eight-Lag Streaming Correlator Chain

The block computes raw lagged products of two sample streams for eight consecutive lags at once. It is a chain of identical single-lag cells. Each cell multiplies the pair of samples it sees, adds the product into its accumulator and counts the samples it used. It hands its A sample on unchanged and its B sample on one sample late. Cell k therefore correlates A against B delayed by k samples. A sample is presented by raising `nd_in` for one clock. The last sample of a record also carries `eod_in`.

One clock after the end marker, every cell copies its accumulated sum and its sample count into a result stage and clears its accumulator and counter. The result stages of all the cells form one serial shift path. The words then leave through the first cell, lag 0 first, one per clock, with `dv_out` high. The chain has the same ports as a single cell: its `d_in`/`n_in`/`dv_in` inputs feed the far end of the shift path, so chains can be joined end to end. A lone chain ties these inputs to zero. There is no controlling state machine.

Top module: `lag_chain`

## Requirements
- R1: A synchronous active-high `rst` clears every register: after reset `d_out`=0, `n_out`=0, `dv_out`=0, and with `nd_in` low `rdy_out`=0.
- R2: Samples are signed 16-bit two's complement. Products are sign-extended and summed modulo 2^32 into a 32-bit sum.
- R3: The count word for lag j equals max(N−j, 0), where N is the number of `nd_in` pulses in the record.
- R4: Let the final sample (with `eod_in`) be taken at clock edge k. Then `dv_out` is low after edge k, high after edges k+1 through k+8, and low again after edge k+9. This makes exactly eight consecutive valid words.
- R5: The j-th valid word (j = 0..7) is lag j: the sum over i = j..N−1 of A[i]·B[i−j].
- R6: `rdy_out` is combinational. Within a record it is high together with `nd_in` from the ninth sample onward and low on the first eight samples and on all cycles without `nd_in`.
- R7: While `rdy_out` is high with sample i, `b_out` equals B[i−8]. `b_out` changes only at edges where `nd_in` was high.
- R8: `a_out` equals `a_in` and `eod_out` equals `eod_in` combinationally.
- R9: The capture clears all accumulators and counters, so each record's results are independent of the records before it.
- R10: Cycles with `nd_in` low between samples do not change any result.
- R11: Lags at or beyond the record length still produce a valid word, with sum 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | A sample, signed |
| b_in | input | 16 | B sample, signed |
| nd_in | input | 1 | Sample strobe |
| eod_in | input | 1 | Marks the current sample as the last of the record |
| d_in | input | 32 | Sum word shifted in at the far end of the result path |
| n_in | input | 16 | Count word shifted in at the far end |
| dv_in | input | 1 | Valid flag shifted in at the far end |
| a_out | output | 16 | A pass-through |
| b_out | output | 16 | B delayed by eight samples |
| rdy_out | output | 1 | Strobe qualifying a_out/b_out for a downstream chain |
| eod_out | output | 1 | End marker pass-through |
| d_out | output | 32 | Raw lagged sum, lag 0 first |
| n_out | output | 16 | Sample count of the current word |
| dv_out | output | 1 | Result word valid |

## Verification
The assertions assume that `nd_in` is low in the clock that follows the end marker, the capture clock. If a sample arrived then, it would be dropped by the clear. The bench always leaves at least that cycle idle and waits for the full result drain before it starts the next record. It also assumes that `eod_in` only arrives on the final sample. Under these rules the bench sweeps records of several lengths: shorter than the lag count, equal to it plus one, and longer. It uses small ascending values, signed mixed patterns with idle gaps, and full-scale extremes that wrap the sum.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;
   localparam int SAMPLE_W_DEF = 16;
   localparam int ACC_W_DEF    = 32;
   localparam int CNT_W_DEF    = 16;
   localparam int LAGS_DEF     = 8;
endpackage

// File: rtl/lag_mac.sv
module lag_mac #(
   parameter int SAMPLE_W  = lagcorr_pkg::SAMPLE_W_DEF,
   parameter int ACC_W     = lagcorr_pkg::ACC_W_DEF,
   parameter int CNT_W     = lagcorr_pkg::CNT_W_DEF,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] a_in,
   input  logic [SAMPLE_W-1:0] b_in,
   input  logic                nd_in,
   input  logic                eod_in,
   output logic [ACC_W-1:0]    acc_q,
   output logic [CNT_W-1:0]    cnt_q,
   output logic                cap_q
);
   localparam int PROD_W = 2 * SAMPLE_W;

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("lag_mac: ACC_W must hold a full product");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("lag_mac: CNT_W must be positive");
   end

   logic [PROD_W-1:0] prod;
   logic [ACC_W-1:0]  prod_ext;

   if (SIGNED_IN) begin : g_signed
      assign prod     = $signed(a_in) * $signed(b_in);
      assign prod_ext = ACC_W'($signed(prod));
   end else begin : g_unsigned
      assign prod     = a_in * b_in;
      assign prod_ext = ACC_W'(prod);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         cnt_q <= '0;
         cap_q <= 1'b0;
      end else begin
         cap_q <= eod_in;
         if (cap_q) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else if (nd_in) begin
            acc_q <= acc_q + prod_ext;
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   // R3: each strobe outside the capture cycle advances the count by one
   assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
      (nd_in && !cap_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R9: a capture leaves the accumulator and counter empty
   assert_capture_clears_R9: assert property (@(posedge clk) disable iff (rst)
      cap_q |=> (acc_q == '0 && cnt_q == '0));
endmodule

// File: rtl/lag_tap.sv
module lag_tap #(
   parameter int SAMPLE_W = lagcorr_pkg::SAMPLE_W_DEF
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] b_in,
   input  logic                nd_in,
   input  logic                cap_in,
   output logic [SAMPLE_W-1:0] b_q,
   output logic                rdy_out
);
   logic primed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         b_q      <= '0;
         primed_q <= 1'b0;
      end else begin
         if (nd_in) begin
            b_q <= b_in;
         end
         if (cap_in) begin
            primed_q <= 1'b0;
         end else if (nd_in) begin
            primed_q <= 1'b1;
         end
      end
   end

   assign rdy_out = nd_in & primed_q;

   // R7: the delayed B sample moves only on a strobe
   assert_b_holds_R7: assert property (@(posedge clk) disable iff (rst)
      !nd_in |=> $stable(b_q));

   // R6: the downstream strobe never appears without an upstream strobe
   assert_rdy_needs_nd_R6: assert property (@(posedge clk) disable iff (rst)
      rdy_out |-> nd_in);

   // R4: input rule, no sample in the capture cycle
   assert_idle_on_capture_R4: assert property (@(posedge clk) disable iff (rst)
      cap_in |-> !nd_in);
endmodule

// File: rtl/lag_result.sv
module lag_result #(
   parameter int ACC_W = lagcorr_pkg::ACC_W_DEF,
   parameter int CNT_W = lagcorr_pkg::CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_in,
   input  logic [ACC_W-1:0] acc_in,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic [ACC_W-1:0] d_in,
   input  logic [CNT_W-1:0] n_in,
   input  logic             dv_in,
   output logic [ACC_W-1:0] d_q,
   output logic [CNT_W-1:0] n_q,
   output logic             dv_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         d_q  <= '0;
         n_q  <= '0;
         dv_q <= 1'b0;
      end else if (cap_in) begin
         d_q  <= acc_in;
         n_q  <= cnt_in;
         dv_q <= 1'b1;
      end else begin
         d_q  <= d_in;
         n_q  <= n_in;
         dv_q <= dv_in;
      end
   end

   // R4: a capture loads the running sum and count and marks them valid
   assert_capture_loads_R4: assert property (@(posedge clk) disable iff (rst)
      cap_in |=> (dv_q && d_q == $past(acc_in) && n_q == $past(cnt_in)));

   // R5: outside a capture the stage shifts its neighbour's word
   assert_shift_path_R5: assert property (@(posedge clk) disable iff (rst)
      !cap_in |=> (d_q == $past(d_in) && n_q == $past(n_in) && dv_q == $past(dv_in)));
endmodule

// File: rtl/lag_cell.sv
module lag_cell #(
   parameter int SAMPLE_W  = lagcorr_pkg::SAMPLE_W_DEF,
   parameter int ACC_W     = lagcorr_pkg::ACC_W_DEF,
   parameter int CNT_W     = lagcorr_pkg::CNT_W_DEF,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] a_in,
   input  logic [SAMPLE_W-1:0] b_in,
   input  logic                nd_in,
   input  logic                eod_in,
   input  logic [ACC_W-1:0]    d_in,
   input  logic [CNT_W-1:0]    n_in,
   input  logic                dv_in,
   output logic [SAMPLE_W-1:0] a_out,
   output logic [SAMPLE_W-1:0] b_out,
   output logic                rdy_out,
   output logic                eod_out,
   output logic [ACC_W-1:0]    d_out,
   output logic [CNT_W-1:0]    n_out,
   output logic                dv_out
);
   logic [ACC_W-1:0] acc;
   logic [CNT_W-1:0] cnt;
   logic             cap;

   lag_mac #(
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W),
      .CNT_W    (CNT_W),
      .SIGNED_IN(SIGNED_IN)
   ) u_mac (
      .clk   (clk),
      .rst   (rst),
      .a_in  (a_in),
      .b_in  (b_in),
      .nd_in (nd_in),
      .eod_in(eod_in),
      .acc_q (acc),
      .cnt_q (cnt),
      .cap_q (cap)
   );

   lag_tap #(
      .SAMPLE_W(SAMPLE_W)
   ) u_tap (
      .clk    (clk),
      .rst    (rst),
      .b_in   (b_in),
      .nd_in  (nd_in),
      .cap_in (cap),
      .b_q    (b_out),
      .rdy_out(rdy_out)
   );

   lag_result #(
      .ACC_W(ACC_W),
      .CNT_W(CNT_W)
   ) u_res (
      .clk   (clk),
      .rst   (rst),
      .cap_in(cap),
      .acc_in(acc),
      .cnt_in(cnt),
      .d_in  (d_in),
      .n_in  (n_in),
      .dv_in (dv_in),
      .d_q   (d_out),
      .n_q   (n_out),
      .dv_q  (dv_out)
   );

   assign a_out   = a_in;
   assign eod_out = eod_in;
endmodule

// File: rtl/lag_chain.sv
module lag_chain #(
   parameter int SAMPLE_W  = lagcorr_pkg::SAMPLE_W_DEF,
   parameter int ACC_W     = lagcorr_pkg::ACC_W_DEF,
   parameter int CNT_W     = lagcorr_pkg::CNT_W_DEF,
   parameter int LAGS      = lagcorr_pkg::LAGS_DEF,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] a_in,
   input  logic [SAMPLE_W-1:0] b_in,
   input  logic                nd_in,
   input  logic                eod_in,
   input  logic [ACC_W-1:0]    d_in,
   input  logic [CNT_W-1:0]    n_in,
   input  logic                dv_in,
   output logic [SAMPLE_W-1:0] a_out,
   output logic [SAMPLE_W-1:0] b_out,
   output logic                rdy_out,
   output logic                eod_out,
   output logic [ACC_W-1:0]    d_out,
   output logic [CNT_W-1:0]    n_out,
   output logic                dv_out
);
   localparam int RUN_W = $clog2(LAGS + 1);

   if (LAGS < 1 || LAGS > 256) begin : g_bad_lags
      $error("lag_chain: LAGS out of range");
   end

   logic [SAMPLE_W-1:0] a_w   [0:LAGS];
   logic [SAMPLE_W-1:0] b_w   [0:LAGS];
   logic                nd_w  [0:LAGS];
   logic                eod_w [0:LAGS];
   logic [ACC_W-1:0]    d_w   [0:LAGS];
   logic [CNT_W-1:0]    n_w   [0:LAGS];
   logic                dv_w  [0:LAGS];

   assign a_w[0]    = a_in;
   assign b_w[0]    = b_in;
   assign nd_w[0]   = nd_in;
   assign eod_w[0]  = eod_in;
   assign d_w[LAGS]  = d_in;
   assign n_w[LAGS]  = n_in;
   assign dv_w[LAGS] = dv_in;

   for (genvar k = 0; k < LAGS; k++) begin : g_cell
      lag_cell #(
         .SAMPLE_W (SAMPLE_W),
         .ACC_W    (ACC_W),
         .CNT_W    (CNT_W),
         .SIGNED_IN(SIGNED_IN)
      ) u_cell (
         .clk    (clk),
         .rst    (rst),
         .a_in   (a_w[k]),
         .b_in   (b_w[k]),
         .nd_in  (nd_w[k]),
         .eod_in (eod_w[k]),
         .d_in   (d_w[k+1]),
         .n_in   (n_w[k+1]),
         .dv_in  (dv_w[k+1]),
         .a_out  (a_w[k+1]),
         .b_out  (b_w[k+1]),
         .rdy_out(nd_w[k+1]),
         .eod_out(eod_w[k+1]),
         .d_out  (d_w[k]),
         .n_out  (n_w[k]),
         .dv_out (dv_w[k])
      );
   end

   assign a_out   = a_w[LAGS];
   assign b_out   = b_w[LAGS];
   assign rdy_out = nd_w[LAGS];
   assign eod_out = eod_w[LAGS];
   assign d_out   = d_w[0];
   assign n_out   = n_w[0];
   assign dv_out  = dv_w[0];

   // Length of the current run of valid words, used only by the check below
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (dv_out) begin
         run_q <= run_q + RUN_W'(1);
      end else begin
         run_q <= '0;
      end
   end

   // R4: with the far end tied low, no run of valid words exceeds LAGS
   assert_valid_window_R4: assert property (@(posedge clk) disable iff (rst)
      (dv_out && !dv_in) |-> (run_q < RUN_W'(LAGS)));
endmodule

// File: tb/tb_lag_chain.sv
module tb_lag_chain;
   localparam int CLK_PERIOD = 10;
   localparam int LAGS = 8;
   localparam int MAXN = 32;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] a_in = '0;
   logic [15:0] b_in = '0;
   logic        nd_in = 1'b0;
   logic        eod_in = 1'b0;
   logic [15:0] a_out, b_out, n_out;
   logic        rdy_out, eod_out, dv_out;
   logic [31:0] d_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int sa [0:MAXN-1];
   int sb [0:MAXN-1];

   always #(CLK_PERIOD/2) clk = ~clk;

   lag_chain dut (
      .clk(clk), .rst(rst),
      .a_in(a_in), .b_in(b_in), .nd_in(nd_in), .eod_in(eod_in),
      .d_in(32'd0), .n_in(16'd0), .dv_in(1'b0),
      .a_out(a_out), .b_out(b_out), .rdy_out(rdy_out), .eod_out(eod_out),
      .d_out(d_out), .n_out(n_out), .dv_out(dv_out)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic longint lag_sum(input int j, input int n);
      longint s = 0;
      for (int i = j; i < n; i++) s += longint'(sa[i]) * longint'(sb[i-j]);
      return s;
   endfunction

   // Send n samples from sa/sb; gap inserts an idle cycle after every third sample
   task automatic run_record(input int n, input bit gap);
      logic [31:0] exp_d;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         a_in = 16'(sa[i]);
         b_in = 16'(sb[i]);
         nd_in = 1'b1;
         eod_in = (i == n-1);
         #1;
         chk(a_out == a_in, "R8 a_out", a_out, a_in);
         chk(eod_out == eod_in, "R8 eod_out", eod_out, eod_in);
         chk(rdy_out == (i >= LAGS), "R6 rdy_out", rdy_out, i >= LAGS);
         if (i >= LAGS)
            chk(b_out == 16'(sb[i-LAGS]), "R7 b_out", b_out, 16'(sb[i-LAGS]));
         if (gap && (i % 3 == 1) && i != n-1) begin
            @(negedge clk);
            nd_in = 1'b0;
            eod_in = 1'b0;
            #1;
            chk(rdy_out == 1'b0, "R10 rdy idle", rdy_out, 0);
         end
      end
      @(negedge clk);
      nd_in = 1'b0;
      eod_in = 1'b0;
      chk(dv_out == 1'b0, "R4 not yet valid", dv_out, 0);
      for (int j = 0; j < LAGS; j++) begin
         @(negedge clk);
         exp_d = 32'(lag_sum(j, n));
         chk(dv_out == 1'b1, "R4 valid run", dv_out, 1);
         chk(d_out == exp_d, "R5 R2 lag sum", d_out, exp_d);
         chk(n_out == 16'((n > j) ? n - j : 0), "R3 R11 count", n_out, (n > j) ? n - j : 0);
      end
      @(negedge clk);
      chk(dv_out == 1'b0, "R4 run ends", dv_out, 0);
      chk(d_out == 32'd0, "R4 tail zero", d_out, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL R4 watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      chk(d_out == 32'd0, "R1 d_out", d_out, 0);
      chk(n_out == 16'd0, "R1 n_out", n_out, 0);
      chk(dv_out == 1'b0, "R1 dv_out", dv_out, 0);
      chk(rdy_out == 1'b0, "R1 rdy_out", rdy_out, 0);

      // R5 R3: ascending 1..9 on both streams
      for (int i = 0; i < 9; i++) begin sa[i] = i + 1; sb[i] = i + 1; end
      run_record(9, 1'b0);

      // R11: record shorter than the lag count
      for (int i = 0; i < 3; i++) begin sa[i] = i + 1; sb[i] = i + 1; end
      run_record(3, 1'b0);

      // R2 R10: signed mixed pattern with idle gaps
      for (int i = 0; i < 20; i++) begin
         sa[i] = ((i * 37) % 201) - 100;
         sb[i] = 77 - ((i * 53) % 151);
      end
      run_record(20, 1'b1);

      // R2: full-scale extremes wrap the 32-bit sum
      for (int i = 0; i < 12; i++) begin sa[i] = -32768; sb[i] = 32767; end
      run_record(12, 1'b0);

      // R9: next record starts clean after the large one
      for (int i = 0; i < 11; i++) begin sa[i] = i - 5; sb[i] = 2 * i + 1; end
      run_record(11, 1'b0);

      // R6 R7: longest record, ready and delayed B across many samples
      for (int i = 0; i < MAXN; i++) begin sa[i] = (i * 11) % 29 - 14; sb[i] = i; end
      run_record(MAXN, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule